// File: doc/BRIEF.md
# Dual-Channel Attenuation Code Front End

This block keeps a 6-bit attenuation code for each of two gain channels and decides, from a two-bit mode input, where each code is taken from. Bit k of a code is worth 2^k half-decibels (0.5 dB for bit 0 up to 16 dB for bit 5). A code of all zeros is maximum gain, and every set bit removes its own weight from the gain.

In parallel mode, each channel copies its own six code inputs while its hold input is low, and freezes its code while the hold input is high. In serial mode and in pulse mode, the codes come from an update bus driven by an external serial register engine or an external step engine. Each channel's code changes only when that channel's valid strobe is high.

The mode input is asynchronous and passes through two flops first. The pins float high when unconnected, so reset selects parallel mode. The decoded source is given as a one-hot select, which the external engines use to know when they own the codes. Each channel's enable input is registered and passed through.

Top module: `atten_mode_front`

## Requirements
- R1: A synchronous active-low reset sets both codes to 000000, both enable outputs to 0, the active mode to 11 and the source select to 3'b001.
- R2: The active mode is decoded as follows: 11 is parallel (`src_sel` = 3'b001), 10 is serial (3'b010), 01 is pulse (3'b100) and 00 is reserved (3'b000). At most one select bit is ever high.
- R3: `active_mode` equals the value `mode_pins` had at the rising edge two edges earlier. It never changes earlier than that.
- R4: In parallel mode, a channel whose hold bit is 0 shows its `par_code` slice on `gain_code` one clock edge later. Channel c uses bits [6c+5:6c].
- R5: In parallel mode, a channel whose hold bit is 1 keeps its code unchanged, whatever its `par_code` slice does.
- R6: The two channels are independent. The hold bit, the valid strobe and the code slice of one channel never affect the other channel.
- R7: In serial mode, a channel with `upd_valid` = 1 takes its `upd_code` slice one edge later. A channel with `upd_valid` = 0 keeps its code.
- R8: In pulse mode, the update bus behaves the same way as in R7.
- R9: In serial and pulse mode, `par_code` and `par_hold` have no effect. In parallel mode, `upd_valid` and `upd_code` have no effect.
- R10: In reserved mode 00, both codes hold, whatever any data input does.
- R11: `en_out` equals `en_in` as sampled at the previous rising edge. Enable is active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_pins | input | 2 | Asynchronous mode selection, {high bit, low bit} |
| par_code | input | 12 | Parallel code inputs, channel c at [6c+5:6c] |
| par_hold | input | 2 | Per-channel hold, 1 freezes the code in parallel mode |
| upd_valid | input | 2 | Per-channel update strobe from the serial or pulse engine |
| upd_code | input | 12 | Update bus codes, channel c at [6c+5:6c] |
| en_in | input | 2 | Per-channel enable request |
| en_out | output | 2 | Registered per-channel enable |
| gain_code | output | 12 | Current attenuation codes, channel c at [6c+5:6c] |
| active_mode | output | 2 | Synchronized mode in use |
| src_sel | output | 3 | One-hot source: bit0 parallel, bit1 serial, bit2 pulse |

## Verification
Code and enable outputs react one rising edge after their inputs. `active_mode` and `src_sel` react two edges after a change on `mode_pins`. A code driven by a new mode therefore reacts on the third edge. The bench drives every input at a falling edge. On each rising edge it advances its own model by exactly these delays, and it compares all outputs at the next falling edge, so every result is sampled in the cycle it is due.

// File: rtl/atten_pkg.sv
// Shared types for the attenuation code front end.
// Assumes a two-bit mode word whose all-ones value is the power-up default.
package atten_pkg;
    typedef enum logic [1:0] {
        MODE_RSV = 2'b00,
        MODE_PLS = 2'b01,
        MODE_SER = 2'b10,
        MODE_PAR = 2'b11
    } atten_mode_e;

    localparam int SRC_W   = 3;
    localparam int SRC_PAR = 0;
    localparam int SRC_SER = 1;
    localparam int SRC_PLS = 2;
endpackage

// File: rtl/mode_sync.sv
// Brings the asynchronous mode pins into the clock domain through two
// flops and decodes the result into a one-hot source select.
// Assumes the pins are quasi-static; a glitch shorter than a cycle may be
// seen for one cycle only.
module mode_sync
    import atten_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_pins,
    output atten_mode_e      mode_q,
    output logic [SRC_W-1:0] src_sel
);
    logic [1:0]  stage1;
    atten_mode_e stage2;

    // Two-flop synchronizer, reset to the parallel default.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= 2'b11;
            stage2 <= MODE_PAR;
        end else begin
            stage1 <= mode_pins;
            stage2 <= atten_mode_e'(stage1);
        end
    end

    // Decode the synchronized mode into one-hot source select.
    always_comb begin
        src_sel = '0;
        case (stage2)
            MODE_PAR: src_sel[SRC_PAR] = 1'b1;
            MODE_SER: src_sel[SRC_SER] = 1'b1;
            MODE_PLS: src_sel[SRC_PLS] = 1'b1;
            default:  src_sel = '0;
        endcase
    end

    assign mode_q = stage2;

    // R2
    src_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_sel));

    // R3
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (mode_q == atten_mode_e'($past(stage1))));
endmodule

// File: rtl/chan_code.sv
// One channel's attenuation code register. In parallel mode it behaves as a
// hold-controlled latch sampled on the clock. In serial and pulse mode it
// loads from the update bus when strobed. In reserved mode it keeps its code.
// Assumes all data inputs are synchronous to clk.
module chan_code
    import atten_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  atten_mode_e       mode,
    input  logic [CODE_W-1:0] par_code,
    input  logic              par_hold,
    input  logic              upd_valid,
    input  logic [CODE_W-1:0] upd_code,
    output logic [CODE_W-1:0] code_q
);
    logic [CODE_W-1:0] code_nx;

    // Pick the next code from the source the mode selects.
    always_comb begin
        code_nx = code_q;
        case (mode)
            MODE_PAR: if (!par_hold) code_nx = par_code;
            MODE_SER,
            MODE_PLS: if (upd_valid) code_nx = upd_code;
            default:  code_nx = code_q;
        endcase
    end

    // Code register, cleared to maximum gain on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code_nx;
    end

    // R5
    par_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PAR && par_hold) |=> $stable(code_q));

    // R4
    par_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PAR && !par_hold) |=> (code_q == $past(par_code)));

    // R10
    rsv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RSV) |=> $stable(code_q));

    // R7
    upd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_SER || mode == MODE_PLS) && upd_valid)
        |=> (code_q == $past(upd_code)));

    // R9
    upd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_SER || mode == MODE_PLS) && !upd_valid)
        |=> $stable(code_q));
endmodule

// File: rtl/atten_mode_front.sv
// Top of the dual-channel attenuation code front end. It synchronizes the
// mode pins, instantiates one code register per channel, and registers the
// per-channel enables. Assumes the serial and pulse engines drive the update
// bus only while their bit of src_sel is set.
module atten_mode_front
    import atten_pkg::*;
#(
    parameter int N_CH   = 2,
    parameter int CODE_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             mode_pins,
    input  logic [N_CH*CODE_W-1:0] par_code,
    input  logic [N_CH-1:0]        par_hold,
    input  logic [N_CH-1:0]        upd_valid,
    input  logic [N_CH*CODE_W-1:0] upd_code,
    input  logic [N_CH-1:0]        en_in,
    output logic [N_CH-1:0]        en_out,
    output logic [N_CH*CODE_W-1:0] gain_code,
    output logic [1:0]             active_mode,
    output logic [SRC_W-1:0]       src_sel
);
    atten_mode_e mode_q;

    mode_sync u_mode_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_pins (mode_pins),
        .mode_q    (mode_q),
        .src_sel   (src_sel)
    );

    assign active_mode = mode_q;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        chan_code #(.CODE_W(CODE_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode      (mode_q),
            .par_code  (par_code[ch*CODE_W +: CODE_W]),
            .par_hold  (par_hold[ch]),
            .upd_valid (upd_valid[ch]),
            .upd_code  (upd_code[ch*CODE_W +: CODE_W]),
            .code_q    (gain_code[ch*CODE_W +: CODE_W])
        );
    end

    // Enable pass-through register, disabled on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) en_out <= '0;
        else        en_out <= en_in;
    end

    // R11
    en_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (en_out == $past(en_in)));
endmodule

// File: tb/test_atten_mode_front.sv
// Self-checking bench: sweeps all 64 codes per channel through every mode
// and compares against a cycle model built from the requirements.
module test_atten_mode_front;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 2;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    mode_pins;
    logic [NC*CW-1:0] par_code, upd_code, gain_code;
    logic [NC-1:0] par_hold, upd_valid, en_in, en_out;
    logic [1:0]    active_mode;
    logic [2:0]    src_sel;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [CW-1:0] exp_code [NC];
    logic [1:0]    s1, s2;
    logic [NC-1:0] exp_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    atten_mode_front i_atten_mode_front (
        .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins),
        .par_code(par_code), .par_hold(par_hold), .upd_valid(upd_valid),
        .upd_code(upd_code), .en_in(en_in), .en_out(en_out),
        .gain_code(gain_code), .active_mode(active_mode), .src_sel(src_sel)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] sel_of(logic [1:0] m);
        case (m)
            2'b11:   return 3'b001;
            2'b10:   return 3'b010;
            2'b01:   return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

    // One clock: advance the model at the rising edge, compare at the falling edge.
    task automatic tick(string req);
        logic [CW-1:0] nc [NC];
        for (int c = 0; c < NC; c++) begin
            nc[c] = exp_code[c];
            if (s2 == 2'b11 && !par_hold[c]) nc[c] = par_code[c*CW +: CW];
            if ((s2 == 2'b10 || s2 == 2'b01) && upd_valid[c]) nc[c] = upd_code[c*CW +: CW];
        end
        @(posedge clk);
        if (!rst_n) begin
            for (int c = 0; c < NC; c++) exp_code[c] = '0;
            s1 = 2'b11; s2 = 2'b11; exp_en = '0;
        end else begin
            for (int c = 0; c < NC; c++) exp_code[c] = nc[c];
            s2 = s1; s1 = mode_pins; exp_en = en_in;
        end
        @(negedge clk);
        for (int c = 0; c < NC; c++)
            chk(c == 1 && req == "R5" ? "R6" : req, int'(gain_code[c*CW +: CW]), int'(exp_code[c]));
        chk("R3", int'(active_mode), int'(s2));
        chk("R2", int'(src_sel), int'(sel_of(s2)));
        chk("R11", int'(en_out), int'(exp_en));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; mode_pins = 2'b11; par_code = '0; upd_code = '0;
        par_hold = '0; upd_valid = '0; en_in = '0;
        for (int c = 0; c < NC; c++) exp_code[c] = '0;
        s1 = 2'b11; s2 = 2'b11; exp_en = '0;
        @(negedge clk);
        en_in = 2'b11; par_code = 12'hFFF;
        tick("R1"); tick("R1");
        // R1 explicit reset state
        chk("R1", int'(gain_code), 0);
        chk("R1", int'(en_out), 0);
        chk("R1", int'(active_mode), 3);
        chk("R1", int'(src_sel), 1);
        rst_n = 1;

        // R4: transparent sweep, channels driven with different codes (R6)
        for (int v = 0; v < 64; v++) begin
            par_code = {6'(63 - v), 6'(v)};
            tick("R4");
        end
        // R5: channel 0 held, channel 1 transparent
        par_hold = 2'b01;
        for (int v = 0; v < 64; v++) begin
            par_code = {6'(v), 6'(v ^ 6'h2A)};
            tick("R5");
        end
        par_hold = 2'b11;
        for (int v = 0; v < 16; v++) begin
            par_code = {6'(v * 3), 6'(v * 5)};
            tick("R5");
        end
        // R9: parallel mode ignores the update bus
        par_hold = 2'b11;
        for (int v = 0; v < 16; v++) begin
            upd_valid = 2'b11; upd_code = {6'(v), 6'(~v)};
            tick("R9");
        end
        upd_valid = '0;

        // R3: serial mode becomes active two edges later
        mode_pins = 2'b10;
        tick("R3");
        chk("R3", int'(active_mode), 3);
        tick("R3");
        chk("R3", int'(active_mode), 2);
        // R7: serial updates, parallel inputs toggling (R9)
        par_hold = '0;
        for (int v = 0; v < 64; v++) begin
            upd_valid = 2'(v % 4);
            upd_code = {6'(v), 6'(63 - v)};
            par_code = {6'(v ^ 21), 6'(v ^ 42)};
            tick("R7");
        end
        // R8: pulse mode via the same bus
        mode_pins = 2'b01;
        for (int v = 0; v < 64; v++) begin
            upd_valid = 2'((v + 1) % 4);
            upd_code = {6'(v ^ 6'h15), 6'(v)};
            tick("R8");
        end
        // R10: reserved mode holds everything
        mode_pins = 2'b00;
        tick("R10"); tick("R10");
        for (int v = 0; v < 32; v++) begin
            upd_valid = 2'b11; par_hold = '0;
            upd_code = {6'(v), 6'(v + 7)};
            par_code = {6'(v + 3), 6'(v + 9)};
            tick("R10");
        end
        // R11: enable sweep
        for (int v = 0; v < 8; v++) begin
            en_in = 2'(v);
            tick("R11");
        end
        // R1: reset in mid-run
        rst_n = 0;
        tick("R1");
        chk("R1", int'(gain_code), 0);
        rst_n = 1;
        mode_pins = 2'b11;
        for (int v = 0; v < 4; v++) tick("R4");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule